// File: doc/BRIEF.md
# Synchronous rectifier gate timing generator

This block produces the two secondary-side synchronous rectifier gates for one converter phase. It shares the time-base counter of the primary-side generator but runs its own pair of action points. Each point is the matching primary compare value moved earlier by a programmable lead time. As a result, each rectifier releases before its primary switch releases. A raw rectifier waveform is built from those two points. An active-high complementary dead-band stage then delays every rising edge. Gate A follows the raw waveform, and gate B follows its inverse. Each gate therefore turns on only after the primary switch has turned on.

All settings arrive as shadow inputs. These are the period, the primary switch-on and switch-off compare values, the lead time, the secondary dead band and the primary dead band. They become active together on the cycle in which the shared counter reads zero, so one period never mixes old and new settings. Hardware checks that the secondary dead band is strictly larger than the lead time plus the primary dead band. If that margin is missing, the block reports a fault and holds both gates low.

Top module: `sr_gate_gen`

## Requirements
- R1: While reset is asserted and after it, until a safe setting has been loaded, both gates are low and the fault flag is high (the reset setting is all zero).
- R2: The raw rectifier signal is set when the counter equals the primary switch-on value minus the lead time, and cleared when it equals the primary switch-off value minus the lead time. A difference below zero wraps modulo the period length (period value plus one).
- R3: Gate A rises exactly dead-band-secondary counter ticks after the raw set point, wrapping modulo the period length, and falls at the raw clear point.
- R4: Gate B rises exactly dead-band-secondary ticks after the raw clear point and falls at the raw set point.
- R5: Gate A and gate B are never high at the same time.
- R6: All shadow settings take effect only at the clock edge where the counter reads zero; a change in the middle of a period does not alter the rest of that period.
- R7: When the active secondary dead band is not strictly greater than the active lead time plus the active primary dead band, the fault flag is high and both gates stay low for as long as that setting is active.
- R8: With the lead time equal to the primary dead band, a secondary dead band of exactly twice the primary dead band raises the fault, and one tick more clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cnt_i | input | 10 | Shared up-counting time base, 0 to period |
| prd_sh_i | input | 10 | Shadow period value (last counter value) |
| pri_on_sh_i | input | 10 | Shadow primary switch-on compare |
| pri_off_sh_i | input | 10 | Shadow primary switch-off compare |
| lead_sh_i | input | 10 | Shadow lead time in ticks |
| db_sec_sh_i | input | 10 | Shadow secondary dead band in ticks |
| db_pri_sh_i | input | 10 | Shadow primary dead band in ticks |
| gate_a_o | output | 1 | Rectifier gate A |
| gate_b_o | output | 1 | Rectifier gate B (complement path) |
| fault_o | output | 1 | Dead-band margin violation |

## Verification
The assertions assume that the shared counter counts up by one from zero to the active period value and then returns to zero. They also assume that both primary compare values and the lead time never exceed the period value; under that assumption the derived action points stay inside the counter range. The bench drives the counter itself, one step per clock, over exactly the period range it has loaded. Every setting it applies keeps the compare values and the lead time below the period. Setting changes are made only with the period value held fixed, so the counter range the bench drives always matches the active period.

// File: rtl/sr_pkg.sv
package sr_pkg;

    parameter int unsigned SR_CW = 10;
    localparam int unsigned SR_XW = SR_CW + 1;

    typedef logic [SR_CW-1:0] cnt_t;
    typedef logic [SR_XW-1:0] ext_t;

    localparam cnt_t AGE_MAX = {SR_CW{1'b1}};
    localparam int unsigned N_PTS = 2;

    // index into point arrays
    localparam int unsigned PT_ON  = 0;
    localparam int unsigned PT_OFF = 1;

    typedef struct packed {
        cnt_t prd;
        cnt_t pri_on;
        cnt_t pri_off;
        cnt_t lead;
        cnt_t db_sec;
        cnt_t db_pri;
    } sr_cfg_t;

    typedef struct packed {
        cnt_t on_pt;
        cnt_t off_pt;
    } sr_evt_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } sr_act_e;

    // Move a compare point earlier by lead ticks, wrapping over period+1.
    function automatic cnt_t lead_back(cnt_t cmp, cnt_t lead, cnt_t prd);
        ext_t span;
        ext_t r;
        span = ext_t'(prd) + ext_t'(1);
        if (cmp >= lead) begin
            r = ext_t'(cmp) - ext_t'(lead);
        end else begin
            r = ext_t'(cmp) + span - ext_t'(lead);
        end
        return r[SR_CW-1:0];
    endfunction

    // Secondary dead band must strictly exceed lead + primary dead band.
    function automatic logic db_unsafe(sr_cfg_t c);
        return ext_t'(c.db_sec) <= (ext_t'(c.lead) + ext_t'(c.db_pri));
    endfunction

endpackage

// File: rtl/sr_shadow_bank.sv
module sr_shadow_bank
    import sr_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  cnt_t    cnt_i,
    input  sr_cfg_t shadow_i,
    output sr_cfg_t active_o
);

    sr_cfg_t act_q;
    logic    at_zero;

    assign at_zero = (cnt_i == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_q <= '0;
        end else if (at_zero) begin
            act_q <= shadow_i;
        end
    end

    assign active_o = act_q;

endmodule

// File: rtl/sr_event_derive.sv
module sr_event_derive
    import sr_pkg::*;
(
    input  sr_cfg_t cfg_i,
    output sr_evt_t evt_o
);

    cnt_t pri_pt [N_PTS];
    cnt_t sec_pt [N_PTS];

    assign pri_pt[PT_ON]  = cfg_i.pri_on;
    assign pri_pt[PT_OFF] = cfg_i.pri_off;

    for (genvar g = 0; g < N_PTS; g++) begin : g_pt
        assign sec_pt[g] = lead_back(pri_pt[g], cfg_i.lead, cfg_i.prd);
    end

    assign evt_o.on_pt  = sec_pt[PT_ON];
    assign evt_o.off_pt = sec_pt[PT_OFF];

endmodule

// File: rtl/sr_action_unit.sv
module sr_action_unit
    import sr_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  cnt_t    cnt_i,
    input  sr_evt_t evt_i,
    output logic    raw_o,
    output logic    raw_next_o
);

    sr_act_e act;
    logic    raw_q;
    logic    raw_d;

    // clear point has priority over set point
    always_comb begin
        if (cnt_i == evt_i.off_pt) begin
            act = ACT_CLR;
        end else if (cnt_i == evt_i.on_pt) begin
            act = ACT_SET;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_comb begin
        case (act)
            ACT_SET: raw_d = 1'b1;
            ACT_CLR: raw_d = 1'b0;
            default: raw_d = raw_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            raw_q <= 1'b0;
        end else begin
            raw_q <= raw_d;
        end
    end

    assign raw_o      = raw_q;
    assign raw_next_o = raw_d;

endmodule

// File: rtl/sr_deadband.sv
module sr_deadband
    import sr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic raw_i,
    input  logic raw_next_i,
    input  cnt_t db_i,
    input  logic block_i,
    output logic gate_a_o,
    output logic gate_b_o
);

    cnt_t age_q;
    logic settled;

    // ticks since the raw signal last changed, saturating
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            age_q <= '0;
        end else if (raw_next_i != raw_i) begin
            age_q <= '0;
        end else if (age_q != AGE_MAX) begin
            age_q <= age_q + cnt_t'(1);
        end
    end

    assign settled  = (age_q >= db_i);
    assign gate_a_o = !block_i &&  raw_i && settled;
    assign gate_b_o = !block_i && !raw_i && settled;

endmodule

// File: rtl/sr_gate_gen.sv
module sr_gate_gen
    import sr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  cnt_t cnt_i,
    input  cnt_t prd_sh_i,
    input  cnt_t pri_on_sh_i,
    input  cnt_t pri_off_sh_i,
    input  cnt_t lead_sh_i,
    input  cnt_t db_sec_sh_i,
    input  cnt_t db_pri_sh_i,
    output logic gate_a_o,
    output logic gate_b_o,
    output logic fault_o
);

    sr_cfg_t shadow_cfg;
    sr_cfg_t act_cfg;
    sr_evt_t evt;
    logic    raw_q;
    logic    raw_next;
    logic    unsafe;

    always_comb begin
        shadow_cfg.prd     = prd_sh_i;
        shadow_cfg.pri_on  = pri_on_sh_i;
        shadow_cfg.pri_off = pri_off_sh_i;
        shadow_cfg.lead    = lead_sh_i;
        shadow_cfg.db_sec  = db_sec_sh_i;
        shadow_cfg.db_pri  = db_pri_sh_i;
    end

    sr_shadow_bank u_bank (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cnt_i    (cnt_i),
        .shadow_i (shadow_cfg),
        .active_o (act_cfg)
    );

    sr_event_derive u_derive (
        .cfg_i (act_cfg),
        .evt_o (evt)
    );

    sr_action_unit u_action (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .cnt_i      (cnt_i),
        .evt_i      (evt),
        .raw_o      (raw_q),
        .raw_next_o (raw_next)
    );

    assign unsafe = db_unsafe(act_cfg);

    sr_deadband u_db (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .raw_i      (raw_q),
        .raw_next_i (raw_next),
        .db_i       (act_cfg.db_sec),
        .block_i    (unsafe),
        .gate_a_o   (gate_a_o),
        .gate_b_o   (gate_b_o)
    );

    assign fault_o = unsafe;

endmodule

// File: rtl/sr_gate_gen_chk.sv
module sr_gate_gen_chk
    import sr_pkg::*;
(
    input logic    clk_i,
    input logic    rst_i,
    input cnt_t    cnt_i,
    input sr_cfg_t act_cfg,
    input sr_evt_t evt,
    input logic    raw_q,
    input logic    gate_a_o,
    input logic    gate_b_o,
    input logic    fault_o
);

    assert_pts_in_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt.on_pt <= act_cfg.prd) && (evt.off_pt <= act_cfg.prd));

    assert_a_rises_on_raw_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(gate_a_o) |-> raw_q);

    assert_b_rises_off_raw_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(gate_b_o) |-> !raw_q);

    assert_gates_exclusive_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !(gate_a_o && gate_b_o));

    assert_load_at_zero_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_i != '0) |=> $stable(act_cfg));

    assert_fault_blocks_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        fault_o |-> (!gate_a_o && !gate_b_o));

endmodule

bind sr_gate_gen sr_gate_gen_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cnt_i    (cnt_i),
    .act_cfg  (act_cfg),
    .evt      (evt),
    .raw_q    (raw_q),
    .gate_a_o (gate_a_o),
    .gate_b_o (gate_b_o),
    .fault_o  (fault_o)
);

// File: tb/sr_gate_gen_test.sv
`timescale 1ns/1ps
module sr_gate_gen_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] cnt, prd_sh, on_sh, off_sh, lead_sh, dbs_sh, dbp_sh;
    logic       gate_a, gate_b, fault;

    int n_total = 0;
    int n_pass  = 0;
    int n_fail  = 0;

    localparam int PRD = 99;

    // per-period observations
    int ar, af, br, bf, both_hi, any_hi, no_flt;
    logic pa, pb;
    int last_l;

    always #2.5 clk = ~clk;

    sr_gate_gen uut (
        .clk_i        (clk),
        .rst_i        (rst),
        .cnt_i        (cnt),
        .prd_sh_i     (prd_sh),
        .pri_on_sh_i  (on_sh),
        .pri_off_sh_i (off_sh),
        .lead_sh_i    (lead_sh),
        .db_sec_sh_i  (dbs_sh),
        .db_pri_sh_i  (dbp_sh),
        .gate_a_o     (gate_a),
        .gate_b_o     (gate_b),
        .fault_o      (fault)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (ok) n_pass++;
        else begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wrapm(input int v);
        return ((v % (PRD + 1)) + (PRD + 1)) % (PRD + 1);
    endfunction

    task automatic set_cfg(input int on_v, input int off_v, input int ld, input int ds, input int dp);
        prd_sh  = 10'(PRD);
        on_sh   = 10'(on_v);
        off_sh  = 10'(off_v);
        lead_sh = 10'(ld);
        dbs_sh  = 10'(ds);
        dbp_sh  = 10'(dp);
    endtask

    // One counter period; optional change of switch points at step chg_at.
    task automatic run_period(input int chg_at, input int n_on, input int n_off);
        ar = -1; af = -1; br = -1; bf = -1;
        both_hi = 0; any_hi = 0; no_flt = 0;
        for (int k = 0; k <= PRD; k++) begin
            @(negedge clk);
            if (gate_a && !pa) ar = last_l;
            if (!gate_a && pa) af = last_l;
            if (gate_b && !pb) br = last_l;
            if (!gate_b && pb) bf = last_l;
            if (gate_a && gate_b) both_hi++;
            if (gate_a || gate_b) any_hi++;
            if (!fault) no_flt++;
            pa = gate_a;
            pb = gate_b;
            if (k == chg_at) begin
                on_sh  = 10'(n_on);
                off_sh = 10'(n_off);
            end
            cnt = 10'(k);
            last_l = k;
        end
    endtask

    task automatic check_edges(input int on_v, input int off_v, input int ld, input int ds, input string tag);
        int s_on, s_off;
        s_on  = wrapm(on_v - ld);
        s_off = wrapm(off_v - ld);
        check(af == s_off, {"R2 gate A falls at derived clear ", tag}, af, s_off);
        check(ar == wrapm(s_on + ds), {"R3 gate A rise delay ", tag}, ar, wrapm(s_on + ds));
        check(br == wrapm(s_off + ds), {"R4 gate B rise delay ", tag}, br, wrapm(s_off + ds));
        check(bf == s_on, {"R4 gate B falls at derived set ", tag}, bf, s_on);
        check(both_hi == 0, {"R5 gates overlap ", tag}, both_hi, 0);
        check(no_flt == PRD + 1, {"R7 fault low when safe ", tag}, no_flt, PRD + 1);
    endtask

    task automatic t_reset_r1();
        rst = 1'b1;
        cnt = '0;
        set_cfg(0, 0, 0, 0, 0);
        prd_sh = '0;
        repeat (3) @(negedge clk);
        check(gate_a == 1'b0, "R1 gate A in reset", int'(gate_a), 0);
        check(gate_b == 1'b0, "R1 gate B in reset", int'(gate_b), 0);
        check(fault == 1'b1, "R1 fault in reset", int'(fault), 1);
        rst = 1'b0;
        @(negedge clk);
        check(!gate_a && !gate_b && fault, "R1 state after reset", int'({gate_a, gate_b, fault}), 1);
        pa = gate_a; pb = gate_b; last_l = 0;
    endtask

    task automatic t_basic();
        set_cfg(10, 60, 4, 9, 3);
        run_period(-1, 0, 0);
        run_period(-1, 0, 0);
        check_edges(10, 60, 4, 9, "basic");
    endtask

    task automatic t_wrap_r2();
        set_cfg(2, 52, 5, 10, 4);
        run_period(-1, 0, 0);
        run_period(-1, 0, 0);
        check_edges(2, 52, 5, 10, "wrap");
    endtask

    task automatic t_load_r6();
        set_cfg(10, 60, 4, 9, 3);
        run_period(-1, 0, 0);
        run_period(-1, 0, 0);
        run_period(30, 20, 70);
        check(af == 56, "R6 old clear point kept mid-period", af, 56);
        check(br == 65, "R6 old gate B rise kept mid-period", br, 65);
        run_period(-1, 0, 0);
        check_edges(20, 70, 4, 9, "after load R6");
    endtask

    task automatic t_fault_r7_r8();
        set_cfg(10, 60, 3, 6, 3);
        run_period(-1, 0, 0);
        run_period(-1, 0, 0);
        check(any_hi == 0, "R7 gates low under fault", any_hi, 0);
        check(no_flt == 0, "R8 fault at twice primary dead band", no_flt, 0);
        set_cfg(10, 60, 3, 7, 3);
        run_period(-1, 0, 0);
        run_period(-1, 0, 0);
        check(no_flt == PRD + 1, "R8 fault clears one tick above", no_flt, PRD + 1);
        check_edges(10, 60, 3, 7, "R8 boundary");
        set_cfg(10, 60, 2, 8, 6);
        run_period(-1, 0, 0);
        run_period(-1, 0, 0);
        check(any_hi == 0 && no_flt == 0, "R7 equal margin faults", any_hi + no_flt, 0);
    endtask

    initial begin
        t_reset_r1();
        t_basic();
        t_wrap_r2();
        t_load_r6();
        t_fault_r7_r8();
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

endmodule